// File: doc/BRIEF.md
# Status Register Group with Transition Filters

This block keeps one group of status flags for a layered status reporting scheme. A vector of 15 live hardware status lines is copied into a condition register on every clock. The block compares each line with its stored copy. A rising change is let through when the matching bit of the rising-edge filter is set. A falling change is let through when the matching bit of the falling-edge filter is set. Any change that passes is latched into a sticky event register. The event register is ANDed with an enable mask and ORed down to one summary bit, which feeds the next level of the reporting tree.

Software reaches the five registers through a plain register port with an address, write data, a write strobe, a read strobe and combinational read data. Reading the event register returns its value and clears it at the same clock edge. A preset strobe puts the filter and enable registers back to their defaults. The register port is control traffic, so it has no valid/ready handshake. A strobe takes effect at the clock edge where it is high, and it is never back-pressured. The register width is set by a parameter. The top bit of every register is always zero.

Top module: `status_group`

## Requirements
- R1: Register addresses are: 0 condition, 1 rising filter, 2 falling filter, 3 event, 4 enable. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R2: Bit 15 of read data is always zero. A 1 written to bit 15 of any register does not appear on a later read.
- R3: The condition register reads back the hw_status value that was present at the previous clock edge. Writes to address 0 are ignored.
- R4: The rising filter, falling filter and enable registers hold the value last written to bits 14:0, and it reads back unchanged.
- R5: When bit n of hw_status goes from 0 to 1 while rising-filter bit n is 1, event bit n reads 1 in the cycle after the change.
- R6: When bit n of hw_status goes from 1 to 0 while falling-filter bit n is 1, event bit n reads 1 in the cycle after the change.
- R7: A change whose matching filter bit is 0 leaves the event bit at 0.
- R8: An event bit stays 1 until the event register is read with reg_rd high. That read returns the value and clears the register at the same edge. Writes to address 3 are ignored.
- R9: A new event that arrives in the same cycle as a clearing read of the event register is still set after that edge. The read data shows only the events that were present before that edge.
- R10: summary is 1 exactly when some bit of (event AND enable) is 1. It follows a register change combinationally.
- R11: A preset sets the rising filter to 0x7FFF, the falling filter to 0 and the enable register to 0. A preset wins over a write in the same cycle. The condition and event registers are not changed by a preset.
- R12: After reset, the rising filter reads 0x7FFF and every other register reads 0. summary is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_status | input | 15 | Live hardware status lines |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears the event register when address is 3 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| preset | input | 1 | Restore filter and enable defaults |
| summary | output | 1 | OR of enabled event bits |

## Verification
A clearing read of the event register and the latching of a new transition can land on the same clock edge. The bench provokes this by raising a second status line in the very cycle in which it reads the event register. It then judges two things: the read data must show only the earlier event, and the event register must hold only the new bit afterwards. Preset and a register write are also driven together in one cycle. Every filter register must then read its preset value.

// File: rtl/status_group_pkg.sv
package status_group_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_COND = 3'd0,
    SEL_RISE = 3'd1,
    SEL_FALL = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_ENA  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/status_cfg_reg.sv
// One writable configuration register with separate reset and preset values.
module status_cfg_reg #(
  parameter int BITS = 15,
  parameter logic [BITS-1:0] RST_VAL = '0,
  parameter logic [BITS-1:0] PRESET_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            preset,
  input  logic [BITS-1:0] wdata,
  output logic [BITS-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= RST_VAL;
    else if (preset) value <= PRESET_VAL;
    else if (wr_en)  value <= wdata;
  end
endmodule

// File: rtl/status_edge_detect.sv
// Condition register plus per-bit transition filtering.
module status_edge_detect #(
  parameter int BITS = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] live,
  input  logic [BITS-1:0] rise_mask,
  input  logic [BITS-1:0] fall_mask,
  output logic [BITS-1:0] cond,
  output logic [BITS-1:0] evt_set
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond <= '0;
    else        cond <= live;
  end

  for (genvar b = 0; b < BITS; b++) begin : g_bit
    logic went_up, went_down;
    assign went_up    = live[b] & ~cond[b];
    assign went_down  = ~live[b] & cond[b];
    assign evt_set[b] = (went_up & rise_mask[b]) | (went_down & fall_mask[b]);
  end
endmodule

// File: rtl/status_event_latch.sv
// Sticky event bits; a clear and a new set at one edge leave the new set.
module status_event_latch #(
  parameter int BITS = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [BITS-1:0] set,
  output logic [BITS-1:0] evt
);
  logic [BITS-1:0] keep;
  assign keep = clr ? '0 : evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= keep | set;
  end
endmodule

// File: rtl/status_group.sv
module status_group
  import status_group_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_W-2:0]     hw_status,
  input  logic [SEL_W-1:0]     reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 preset,
  output logic                 summary
);
  localparam int BITS = REG_W - 1;
  localparam logic [BITS-1:0] ALL_ONES = '1;

  logic [BITS-1:0] cond_q, ptr_q, ntr_q, ena_q, evt_q, evt_set;
  logic            wr_ptr, wr_ntr, wr_ena, evt_clr;
  logic [BITS-1:0] wbits;

  assign wbits   = reg_wdata[BITS-1:0];
  assign wr_ptr  = reg_wr && (reg_addr == SEL_RISE);
  assign wr_ntr  = reg_wr && (reg_addr == SEL_FALL);
  assign wr_ena  = reg_wr && (reg_addr == SEL_ENA);
  assign evt_clr = reg_rd && (reg_addr == SEL_EVT);

  status_cfg_reg #(.BITS(BITS), .RST_VAL(ALL_ONES), .PRESET_VAL(ALL_ONES)) u_rise (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ptr), .preset(preset), .wdata(wbits), .value(ptr_q));

  status_cfg_reg #(.BITS(BITS), .RST_VAL('0), .PRESET_VAL('0)) u_fall (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ntr), .preset(preset), .wdata(wbits), .value(ntr_q));

  status_cfg_reg #(.BITS(BITS), .RST_VAL('0), .PRESET_VAL('0)) u_ena (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ena), .preset(preset), .wdata(wbits), .value(ena_q));

  status_edge_detect #(.BITS(BITS)) u_edge (
    .clk(clk), .rst_n(rst_n), .live(hw_status), .rise_mask(ptr_q), .fall_mask(ntr_q),
    .cond(cond_q), .evt_set(evt_set));

  status_event_latch #(.BITS(BITS)) u_evt (
    .clk(clk), .rst_n(rst_n), .clr(evt_clr), .set(evt_set), .evt(evt_q));

  logic [BITS-1:0] sel_val;
  always_comb begin
    case (reg_addr)
      SEL_COND: sel_val = cond_q;
      SEL_RISE: sel_val = ptr_q;
      SEL_FALL: sel_val = ntr_q;
      SEL_EVT:  sel_val = evt_q;
      SEL_ENA:  sel_val = ena_q;
      default:  sel_val = '0;
    endcase
  end

  assign reg_rdata = {1'b0, sel_val};
  assign summary   = |(evt_q & ena_q);
endmodule

// File: rtl/status_group_chk.sv
module status_group_chk
  import status_group_pkg::*;
#(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-2:0] hw_status,
  input logic [REG_W-2:0] cond_q,
  input logic [REG_W-2:0] ptr_q,
  input logic [REG_W-2:0] ntr_q,
  input logic [REG_W-2:0] ena_q,
  input logic [REG_W-2:0] evt_q,
  input logic [SEL_W-1:0] reg_addr,
  input logic             reg_rd,
  input logic [REG_W-1:0] reg_rdata,
  input logic             preset,
  input logic             summary
);
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R2
  msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1] == 1'b0);

  // R3
  cond_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> cond_q == $past(hw_status));

  // R5
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (($past(hw_status) & ~$past(cond_q) & $past(ptr_q)) & ~evt_q) == '0);

  // R6
  fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((~$past(hw_status) & $past(cond_q) & $past(ntr_q)) & ~evt_q) == '0);

  // R8
  sticky_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(reg_rd && reg_addr == SEL_EVT)) |-> ($past(evt_q) & ~evt_q) == '0);

  // R10
  summary_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ena_q) == '0) |-> !summary);

  // R10
  summary_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ena_q) != '0) |-> summary);

  // R11
  preset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(preset)) |-> (ptr_q == '1 && ntr_q == '0 && ena_q == '0));
endmodule

bind status_group status_group_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_status(hw_status), .cond_q(cond_q), .ptr_q(ptr_q),
  .ntr_q(ntr_q), .ena_q(ena_q), .evt_q(evt_q), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .preset(preset), .summary(summary));

// File: tb/status_group_bench.sv
module status_group_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] hw_status;
  logic [2:0]  reg_addr;
  logic        reg_wr, reg_rd, preset;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        summary;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_group u_status_group (
    .clk(clk), .rst_n(rst_n), .hw_status(hw_status), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .preset(preset), .summary(summary));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    reg_rd = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; hw_status = '0; reg_addr = '0; reg_wr = 0; reg_rd = 0;
    preset = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset values
    peek(3'd0, v); check("R12 cond", v, 16'h0000);
    peek(3'd1, v); check("R12 rise", v, 16'h7FFF);
    peek(3'd2, v); check("R12 fall", v, 16'h0000);
    peek(3'd3, v); check("R12 evt",  v, 16'h0000);
    peek(3'd4, v); check("R12 ena",  v, 16'h0000);
    check("R12 summary", {15'd0, summary}, 16'h0000);

    // R4 / R2 write and read back, bit 15 dropped
    wr(3'd1, 16'hFFFF); peek(3'd1, v); check("R2 rise msb", v, 16'h7FFF);
    wr(3'd2, 16'hA5A5); peek(3'd2, v); check("R4 fall", v, 16'h25A5);
    wr(3'd4, 16'h1234); peek(3'd4, v); check("R4 ena", v, 16'h1234);
    wr(3'd1, 16'h0F0F); peek(3'd1, v); check("R4 rise", v, 16'h0F0F);

    // R1 unused addresses
    for (int a = 5; a < 8; a++) begin
      wr(a[2:0], 16'h7FFF); peek(a[2:0], v); check("R1 unused", v, 16'h0000);
    end
    peek(3'd2, v); check("R1 fall untouched", v, 16'h25A5);

    // R3 condition follows input one cycle later; writes ignored
    wr(3'd2, 16'h0000); wr(3'd1, 16'h0000);
    hw_status = 15'h5555;
    peek(3'd0, v); check("R3 cond before edge", v, 16'h0000);
    tick();
    peek(3'd0, v); check("R3 cond after edge", v, 16'h5555);
    wr(3'd0, 16'h1234); peek(3'd0, v); check("R3 cond write ignored", v, 16'h5555);
    hw_status = '0; tick();
    rd(3'd3, v); check("R7 no event with filters clear", v, 16'h0000);

    // R8 writes to event ignored
    wr(3'd3, 16'h7FFF); peek(3'd3, v); check("R8 evt write ignored", v, 16'h0000);

    // R5 R6 R7 R10 sweep over every bit and filter combination
    for (int i = 0; i < 15; i++) begin
      for (int p = 0; p < 4; p++) begin
        logic [15:0] bitv;
        bitv = 16'(1) << i;
        wr(3'd1, p[0] ? bitv : 16'h0);
        wr(3'd2, p[1] ? bitv : 16'h0);
        wr(3'd4, bitv);
        hw_status[i] = 1'b1; tick();
        check("R10 summary rise", {15'd0, summary}, {15'd0, p[0]});
        rd(3'd3, v); check("R5 rise event", v, p[0] ? bitv : 16'h0);
        check("R8 cleared by read", {15'd0, summary}, 16'h0000);
        hw_status[i] = 1'b0; tick();
        check("R10 summary fall", {15'd0, summary}, {15'd0, p[1]});
        rd(3'd3, v); check("R6 fall event", v, p[1] ? bitv : 16'h0);
      end
    end

    // R8 sticky across cycles; R10 enable mismatch
    wr(3'd1, 16'h7FFF); wr(3'd4, 16'h0008);
    hw_status[2] = 1'b1; tick();
    hw_status[2] = 1'b0; tick(); tick();
    peek(3'd3, v); check("R8 sticky", v, 16'h0004);
    check("R10 masked", {15'd0, summary}, 16'h0000);
    wr(3'd4, 16'h000C);
    check("R10 unmasked", {15'd0, summary}, 16'h0001);
    rd(3'd3, v); check("R8 read value", v, 16'h0004);

    // R9 new event in the clearing read cycle
    hw_status[0] = 1'b1; tick();
    hw_status[1] = 1'b1;
    rd(3'd3, v); check("R9 read shows old", v, 16'h0001);
    peek(3'd3, v); check("R9 new survives", v, 16'h0002);

    // R11 preset with simultaneous write
    wr(3'd2, 16'h00FF); wr(3'd4, 16'h0003);
    reg_addr = 3'd1; reg_wdata = 16'h0003; reg_wr = 1'b1; preset = 1'b1;
    tick();
    reg_wr = 1'b0; preset = 1'b0;
    peek(3'd1, v); check("R11 rise preset", v, 16'h7FFF);
    peek(3'd2, v); check("R11 fall preset", v, 16'h0000);
    peek(3'd4, v); check("R11 ena preset", v, 16'h0000);
    peek(3'd0, v); check("R11 cond kept", v, 16'h0003);
    peek(3'd3, v); check("R11 evt kept", v, 16'h0002);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule